// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block turns a 32768 Hz time-base strobe into periodic interrupt ticks. A four-bit rate field picks the period as a power of two of time-base cycles. An enable bit gates the whole tick path. A tick produces a one-cycle pulse that sets the periodic flag and, together with it, a one-cycle interrupt request pulse. The block sits beside the register file of a real-time-clock core. That register file owns the flag and interrupt bits and turns these pulses into sticky state.

Ticks are not counted from the moment the rate is written. A free-running 15-bit counter advances once per time-base strobe. A tick fires on the strobe that moves this counter onto a multiple of the selected period. The tick grid is therefore absolute. Changing the rate, or re-enabling the block, lands the next tick on the next aligned boundary of the new period, and no partial-period pulse is produced.

Top module: `pdiv_top`

## Requirements
- R1: After reset both pulse outputs are low and the strobe counter is zero. With rate code 3 and the enable set, the first tick comes on the 4th strobe after reset.
- R2: Rate code 0 produces no flag pulse and no interrupt pulse, whatever the enable bit is.
- R3: For rate codes 3 to 15 the period is 2^(code-1) strobes. Code 3 gives 4 strobes, code 6 gives 32 strobes (1024 Hz), and code 15 gives 16384 strobes.
- R4: Rate codes 1 and 2 behave as codes 8 and 9, giving periods of 128 and 256 strobes.
- R5: A tick fires exactly on the strobe that makes the total strobe count since reset, modulo 32768, a multiple of the period. The counter wraps from 32767 to 0, and the wrap is itself a boundary.
- R6: While the enable bit is clear, no flag pulse and no interrupt pulse are produced.
- R7: A tick raises both outputs together for exactly one clock cycle. This is the cycle right after the clock edge at which the strobe was sampled high. Neither output is high in any other cycle.
- R8: The counter advances only on strobe cycles, not on every clock. A change of rate code takes effect at the next aligned boundary of the new period, with no extra pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle strobe at the 32768 Hz time-base rate |
| rateCode | input | 4 | Period select: 0 off, 1 and 2 aliased, 3 to 15 give 2^(code-1) strobes |
| pieIn | input | 1 | Periodic interrupt enable |
| flagSetPulse | output | 1 | One-cycle pulse that sets the periodic flag |
| irqPulse | output | 1 | One-cycle interrupt request pulse |

## Verification
Both pulses are due in the cycle right after the edge that sampled the strobe. They are registered once, with no further pipeline. The bench drives inputs on the falling edge and keeps its own tally of strobes. It compares both outputs on the next falling edge in every cycle, so a pulse that is early, late or doubled is caught in the cycle where it happens. Sweeps over every rate code and enable value, a full counter wrap, sparse strobes and mid-stream rate changes are then cross-checked against pulse totals. These totals are counted from the number of period multiples crossed.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;
  // Width of the free-running time-base counter (32768 states).
  localparam int PdCntW  = 15;
  // Width of the rate-select field.
  localparam int PdCodeW = 4;

  // Strobes and qualifiers from control to datapath.
  typedef struct packed {
    logic              advance;    // time-base strobe this cycle
    logic              active;     // nonzero code and enable set
    logic              irqGate;    // interrupt request allowed
    logic [PdCntW-1:0] boundMask;  // period-1, low bits that must be zero
  } pdiv_ctl_t;
endpackage

// File: rtl/pdiv_ctrl.sv
`timescale 1ns/1ps
module pdiv_ctrl
  import pdiv_pkg::*;
#(
  parameter int ALIAS_LIMIT = 2,  // codes 1..ALIAS_LIMIT are remapped
  parameter int ALIAS_ADD   = 7   // remap offset for those codes
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tickEn,
  input  logic [PdCodeW-1:0] rateCode,
  input  logic               pieIn,
  output pdiv_ctl_t          ctl
);
  localparam int ExpW = PdCodeW + 1;

  logic [ExpW-1:0]   effCode;
  logic [ExpW-1:0]   shiftAmt;
  logic              codeOn;
  logic [PdCntW-1:0] maskBits;

  always_comb begin
    codeOn = (rateCode != '0);
    if (codeOn && (int'(rateCode) <= ALIAS_LIMIT))
      effCode = ExpW'(rateCode) + ExpW'(ALIAS_ADD);
    else
      effCode = ExpW'(rateCode);
    shiftAmt = codeOn ? (effCode - ExpW'(1)) : '0;
  end

  // Thermometer mask: bit i set when i is below the period exponent.
  for (genvar gi = 0; gi < PdCntW; gi++) begin : g_mask
    assign maskBits[gi] = codeOn && (ExpW'(gi) < shiftAmt);
  end

  always_comb begin
    ctl.advance   = tickEn;
    ctl.active    = codeOn && pieIn;
    ctl.irqGate   = pieIn;
    ctl.boundMask = maskBits;
  end

  // R3: an active period is a contiguous low mask of at least two bits.
  p_mask_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.active |-> ((((ctl.boundMask + 1'b1) & ctl.boundMask) == '0)
                    && (ctl.boundMask[1:0] == 2'b11)));

  // R4: aliased codes select 128 and 256 strobe periods.
  p_alias_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rateCode == 4'd1) |-> ($countones(ctl.boundMask) == 7));
endmodule

// File: rtl/pdiv_datapath.sv
`timescale 1ns/1ps
module pdiv_datapath
  import pdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pdiv_ctl_t ctl,
  output logic      flagPulse,
  output logic      irqPulse
);
  logic [PdCntW-1:0] baseCount;
  logic [PdCntW-1:0] nextCount;
  logic              onBoundary;
  logic              hit;

  always_comb begin
    nextCount  = baseCount + 1'b1;
    onBoundary = ((nextCount & ctl.boundMask) == '0);
    hit        = ctl.advance && ctl.active && onBoundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseCount <= '0;
      flagPulse <= 1'b0;
      irqPulse  <= 1'b0;
    end else begin
      if (ctl.advance) baseCount <= nextCount;
      flagPulse <= hit;
      irqPulse  <= hit && ctl.irqGate;
    end
  end

  // R7: a pulse only follows a sampled strobe.
  p_pulse_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flagPulse |-> $past(ctl.advance));

  // R7: interrupt request never without the flag pulse.
  p_irq_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> flagPulse);

  // R7: pulses last a single cycle (shortest period is four strobes).
  p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flagPulse |=> !flagPulse);

  // R8: counter holds without a strobe.
  p_count_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.advance |=> $stable(baseCount));

  // R8: counter steps by one per strobe.
  p_count_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.advance |=> (baseCount == $past(baseCount) + 1'b1));

  // R5: a pulse sits on an aligned count for the period in force.
  p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flagPulse |-> ((baseCount & $past(ctl.boundMask)) == '0));
endmodule

// File: rtl/pdiv_top.sv
`timescale 1ns/1ps
module pdiv_top
  import pdiv_pkg::*;
#(
  parameter int ALIAS_LIMIT = 2,
  parameter int ALIAS_ADD   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tickEn,
  input  logic [PdCodeW-1:0] rateCode,
  input  logic               pieIn,
  output logic               flagSetPulse,
  output logic               irqPulse
);
  pdiv_ctl_t ctlBus;

  pdiv_ctrl #(
    .ALIAS_LIMIT(ALIAS_LIMIT),
    .ALIAS_ADD  (ALIAS_ADD)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tickEn  (tickEn),
    .rateCode(rateCode),
    .pieIn   (pieIn),
    .ctl     (ctlBus)
  );

  pdiv_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctlBus),
    .flagPulse(flagSetPulse),
    .irqPulse (irqPulse)
  );

  // R2: code zero keeps both outputs quiet.
  p_zero_code_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rateCode == '0) |=> (!flagSetPulse && !irqPulse));

  // R6: enable clear keeps both outputs quiet.
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pieIn |=> (!flagSetPulse && !irqPulse));
endmodule

// File: tb/pdiv_top_tb.sv
`timescale 1ns/1ps
module pdiv_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic [3:0] rateCode = 4'd0;
  logic       pieIn = 1'b0;
  logic       flagSetPulse;
  logic       irqPulse;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;
  longint total = 0;   // strobes since reset
  int  pulseSeen = 0;

  always #10 clk = ~clk;  // 50 MHz

  pdiv_top u_dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .rateCode(rateCode),
    .pieIn(pieIn), .flagSetPulse(flagSetPulse), .irqPulse(irqPulse)
  );

  function automatic longint periodOf(input logic [3:0] code);
    int e;
    e = (code <= 4'd2) ? int'(code) + 7 : int'(code);
    return longint'(1) << (e - 1);
  endfunction

  function automatic string tagOf(input logic [3:0] code, input logic pie);
    if (code == 4'd0) return "R2";
    if (!pie) return "R6";
    if (code <= 4'd2) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (strobes=%0d)", tag, act, exp, total);
    end
  endtask

  // One cycle: inputs set at falling edge, outputs compared at next falling edge.
  task automatic step(input logic en, input logic [3:0] code, input logic pie,
                      input string tagOverride);
    logic exp;
    string tag;
    tickEn = en; rateCode = code; pieIn = pie;
    @(posedge clk);
    if (en) total++;
    exp = en && (code != 4'd0) && pie && ((total % periodOf(code)) == 0);
    tag = (tagOverride.len() != 0) ? tagOverride : tagOf(code, pie);
    @(negedge clk);
    check({tag, "/R5/R7 flag"}, longint'(flagSetPulse), longint'(exp));
    check({tag, "/R7 irq"}, longint'(irqPulse), longint'(exp));
    if (flagSetPulse) pulseSeen++;
  endtask

  // Run n strobes on one setting and cross-check the pulse total.
  task automatic runSetting(input logic [3:0] code, input logic pie, input int n);
    longint startT, p, expCnt;
    startT = total;
    pulseSeen = 0;
    for (int i = 0; i < n; i++) step(1'b1, code, pie, "");
    p = periodOf(code);
    expCnt = (code != 4'd0 && pie) ? (total / p - startT / p) : 0;
    check({tagOf(code, pie), " pulse total"}, pulseSeen, expCnt);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 flag in reset", flagSetPulse, 0);
    check("R1 irq in reset", irqPulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag after reset", flagSetPulse, 0);
    // R1: first tick on 4th strobe with code 3
    pulseSeen = 0;
    for (int i = 0; i < 3; i++) step(1'b1, 4'd3, 1'b1, "R1");
    check("R1 no early tick", pulseSeen, 0);
    step(1'b1, 4'd3, 1'b1, "R1");
    check("R1 first tick on strobe 4", pulseSeen, 1);

    // Sweep of all codes and enable values.
    for (int c = 0; c < 16; c++)
      for (int pe = 0; pe < 2; pe++)
        runSetting(4'(c), 1'(pe), 1200);

    // R5: full wrap with the longest period.
    runSetting(4'd15, 1'b1, 33000);

    // R8: sparse strobes; the counter counts strobes only.
    pulseSeen = 0;
    begin
      longint st;
      st = total;
      for (int i = 0; i < 300; i++) step((i % 3) == 0, 4'd4, 1'b1, "R8");
      check("R8 sparse pulse total", pulseSeen, total / 8 - st / 8);
    end

    // R8: rate changes mid-stream land on the new grid, no extra pulse.
    begin
      logic [3:0] seq [5];
      longint st, expCnt;
      seq = '{4'd6, 4'd3, 4'd12, 4'd1, 4'd5};
      for (int r = 0; r < 3; r++)
        foreach (seq[k]) begin
          st = total;
          pulseSeen = 0;
          for (int i = 0; i < 37 + 11 * k; i++) step(1'b1, seq[k], 1'b1, "R8");
          expCnt = total / periodOf(seq[k]) - st / periodOf(seq[k]);
          check("R8 change pulse total", pulseSeen, expCnt);
        end
    end

    // R6: clearing the enable mid-period stops pulses.
    for (int i = 0; i < 20; i++) step(1'b1, 4'd3, 1'b0, "R6");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule